// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block decides which pending interrupt a small processor core takes next, and where execution goes for it. It watches five request lines: a trap that cannot be masked, three restart requests of increasing urgency (levels 5.5, 6.5 and 7.5), and one general request. It keeps a global interrupt-enable flag and a three-bit mask for the restart lines. When a request wins, the block either loads a fixed 16-bit service address or, for the general request, starts an acknowledge cycle and reads an instruction byte from the data bus.

The core drives single-cycle command pulses to enable (`ei_i`) or disable (`di_i`) interrupts and to load the restart mask (`mask_wr_i`). Each accepted interrupt produces a one-cycle `take_o` pulse while `pc_o` holds the new address. For the general request, `inta_o` is high for one cycle. The byte on `data_i` during that cycle is decoded. A restart opcode of the form 11nnn111 gives a vector of n times 8. Request lines are level-sensitive and are sampled on every clock edge while the block is idle. Saving the return address is left to the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state after that edge is: `pc_o` = 0x0000, `ie_o` = 0, `mask_o` = 3'b111, and `take_o` and `inta_o` both low.
- R2: A trap request that is seen at an idle edge makes `take_o` pulse after that edge, with `pc_o` = 0x0024. This happens whatever the values of `ie_o` and `mask_o`.
- R3: The restart vectors are 0x003C for level 7.5 (`restart_i[2]`), 0x0034 for level 6.5 (`restart_i[1]`) and 0x002C for level 5.5 (`restart_i[0]`).
- R4: A restart line is serviced only when `ie_o` is 1 and its own mask bit is 0. Mask bit k gates `restart_i[k]`. A `mask_wr_i` pulse loads `mask_data_i` into `mask_o` at the next edge.
- R5: When several requests are eligible at once, exactly one wins, in this order: trap, then 7.5, then 6.5, then 5.5, then the general request.
- R6: The general request is accepted only when `ie_o` is 1. Acceptance drives `inta_o` high for exactly the one cycle after the accepting edge.
- R7: The byte on `data_i` during the `inta_o` cycle is captured at the edge that ends that cycle. If it has the form 11nnn111, `take_o` pulses next with `pc_o` = n*8. For example, 0xE7 gives 0x0020 and 0xFF gives 0x0038.
- R8: A captured byte that is not of the restart form produces no `take_o` pulse and leaves `pc_o` unchanged.
- R9: An `ei_i` pulse sets `ie_o` and a `di_i` pulse clears it. Accepting any interrupt clears `ie_o`, and this takes priority over an `ei_i` pulse at the same edge.
- R10: During the `inta_o` cycle no request is accepted. A trap held across that cycle is taken at the first idle edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_i | input | 1 | Non-maskable trap request |
| restart_i | input | 3 | Restart requests; bit 0 = 5.5, bit 1 = 6.5, bit 2 = 7.5 |
| intr_i | input | 1 | General interrupt request |
| ei_i | input | 1 | Enable-interrupts command pulse |
| di_i | input | 1 | Disable-interrupts command pulse |
| mask_wr_i | input | 1 | Restart mask load strobe |
| mask_data_i | input | 3 | New restart mask value |
| data_i | input | 8 | Instruction byte from the data bus |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| take_o | output | 1 | One-cycle pulse: new service address is valid |
| pc_o | output | 16 | Service address |
| ie_o | output | 1 | Global interrupt-enable flag |
| mask_o | output | 3 | Current restart mask |

## Verification
Each restart line is first raised on its own, with enable set and then clear, and under each single-bit mask. This separates a wrong vector from a wrong gate, and catches mask bits wired to the wrong line. All five requests are then raised together and removed one at a time, which shows the full priority order rather than only the top winner. Acknowledge cycles are run with restart opcodes, non-restart opcodes, a trap held through the strobe, and an enable pulse at the same edge as acceptance. A long stretch of random stimulus follows, compared cycle by cycle against a behavioural model.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

    localparam int ADDR_W  = 16;
    localparam int OP_W    = 8;
    localparam int NUM_RST = 3;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_R75,
        SRC_R65,
        SRC_R55,
        SRC_GEN
    } src_e;

    typedef enum logic {
        ST_IDLE,
        ST_ACK
    } phase_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
    } vec_t;

    localparam logic [ADDR_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [ADDR_W-1:0] VEC_R75  = 16'h003C;
    localparam logic [ADDR_W-1:0] VEC_R65  = 16'h0034;
    localparam logic [ADDR_W-1:0] VEC_R55  = 16'h002C;

    function automatic logic [ADDR_W-1:0] fixed_vec(input src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_R75:  return VEC_R75;
            SRC_R65:  return VEC_R65;
            SRC_R55:  return VEC_R55;
            default:  return '0;
        endcase
    endfunction

    // Restart opcode layout 11nnn111 -> target n*8
    function automatic vec_t decode_op(input logic [OP_W-1:0] op);
        vec_t v;
        v.hit  = (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
        v.addr = {{(ADDR_W-6){1'b0}}, op[5:3], 3'b000};
        return v;
    endfunction

endpackage

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irq_vector_pkg::*;
#(
    parameter int N_RST = NUM_RST
) (
    input  logic             trap,
    input  logic [N_RST-1:0] restart,
    input  logic             intr,
    input  logic             ie,
    input  logic [N_RST-1:0] mask,
    output src_e             win
);
    logic [N_RST-1:0] elig;

    for (genvar k = 0; k < N_RST; k++) begin : g_gate
        assign elig[k] = restart[k] & ~mask[k] & ie;
    end

    always_comb begin
        if (trap)                 win = SRC_TRAP;
        else if (elig[N_RST-1])   win = SRC_R75;
        else if (elig[N_RST-2])   win = SRC_R65;
        else if (elig[0])         win = SRC_R55;
        else if (intr && ie)      win = SRC_GEN;
        else                      win = SRC_NONE;
    end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_vector_pkg::*;
#(
    parameter int N_RST = NUM_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ei,
    input  logic             di,
    input  logic             accept,
    input  logic             mask_wr,
    input  logic [N_RST-1:0] mask_data,
    output logic             ie,
    output logic [N_RST-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie   <= 1'b0;
            mask <= '1;
        end else begin
            if (accept || di) ie <= 1'b0;
            else if (ei)      ie <= 1'b1;
            if (mask_wr)      mask <= mask_data;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = OP_W,
    parameter int N_RST = NUM_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_i,
    input  logic [N_RST-1:0] restart_i,
    input  logic             intr_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             mask_wr_i,
    input  logic [N_RST-1:0] mask_data_i,
    input  logic [DW-1:0]    data_i,
    output logic             inta_o,
    output logic             take_o,
    output logic [AW-1:0]    pc_o,
    output logic             ie_o,
    output logic [N_RST-1:0] mask_o
);
    phase_e phase_q;
    src_e   win;
    logic   accept;
    vec_t   dec;

    irq_vector_arbiter #(.N_RST(N_RST)) arb_i (
        .trap    (trap_i),
        .restart (restart_i),
        .intr    (intr_i),
        .ie      (ie_o),
        .mask    (mask_o),
        .win     (win)
    );

    assign accept = (phase_q == ST_IDLE) && (win != SRC_NONE);

    irq_enable_regs #(.N_RST(N_RST)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .ei        (ei_i),
        .di        (di_i),
        .accept    (accept),
        .mask_wr   (mask_wr_i),
        .mask_data (mask_data_i),
        .ie        (ie_o),
        .mask      (mask_o)
    );

    assign dec    = decode_op(data_i);
    assign inta_o = (phase_q == ST_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            take_o  <= 1'b0;
            pc_o    <= '0;
        end else begin
            take_o <= 1'b0;
            if (phase_q == ST_ACK) begin
                phase_q <= ST_IDLE;
                if (dec.hit) begin
                    take_o <= 1'b1;
                    pc_o   <= dec.addr[AW-1:0];
                end
            end else if (win == SRC_GEN) begin
                phase_q <= ST_ACK;
            end else if (win != SRC_NONE) begin
                take_o <= 1'b1;
                pc_o   <= fixed_vec(win);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int AW    = 16,
    parameter int N_RST = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             trap_i,
    input logic [N_RST-1:0] restart_i,
    input logic             intr_i,
    input logic             inta_o,
    input logic             take_o,
    input logic [AW-1:0]    pc_o,
    input logic             ie_o,
    input logic [N_RST-1:0] mask_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0) && !ie_o && (mask_o == '1) && !take_o && !inta_o);

    assert_trap_vec_R2: assert property (@(posedge clk) disable iff (rst)
        (trap_i && !inta_o) |=> (take_o && pc_o == 16'h0024));

    assert_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!ie_o && !inta_o && !trap_i) |=> (!take_o && !inta_o));

    assert_inta_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        inta_o |=> !inta_o);

    assert_inta_clears_ie_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(inta_o) |-> !ie_o);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(take_o && inta_o));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.AW(AW), .N_RST(N_RST)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .trap_i    (trap_i),
    .restart_i (restart_i),
    .intr_i    (intr_i),
    .inta_o    (inta_o),
    .take_o    (take_o),
    .pc_o      (pc_o),
    .ie_o      (ie_o),
    .mask_o    (mask_o)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_i = 0, intr_i = 0, ei_i = 0, di_i = 0, mask_wr_i = 0;
    logic [2:0]  restart_i = 0, mask_data_i = 0;
    logic [7:0]  data_i = 0;
    logic        inta_o, take_o, ie_o;
    logic [15:0] pc_o;
    logic [2:0]  mask_o;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference state
    bit        m_ie, m_ack, m_take;
    bit [2:0]  m_mask;
    bit [15:0] m_pc;

    always #2.5 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .trap_i(trap_i), .restart_i(restart_i),
        .intr_i(intr_i), .ei_i(ei_i), .di_i(di_i), .mask_wr_i(mask_wr_i),
        .mask_data_i(mask_data_i), .data_i(data_i), .inta_o(inta_o),
        .take_o(take_o), .pc_o(pc_o), .ie_o(ie_o), .mask_o(mask_o)
    );

    task automatic model_edge();
        bit acc = 0;
        bit [15:0] npc = m_pc;
        bit ntake = 0, nack = 0;
        if (rst) begin
            m_ie = 0; m_mask = 3'b111; m_ack = 0; m_pc = 0; m_take = 0;
            return;
        end
        if (m_ack) begin
            if (data_i[7:6] == 2'b11 && data_i[2:0] == 3'b111) begin
                npc = 16'(data_i[5:3]) * 8;
                ntake = 1;
            end
        end else if (trap_i) begin
            npc = 16'h0024; ntake = 1; acc = 1;
        end else if (m_ie && restart_i[2] && !m_mask[2]) begin
            npc = 16'h003C; ntake = 1; acc = 1;
        end else if (m_ie && restart_i[1] && !m_mask[1]) begin
            npc = 16'h0034; ntake = 1; acc = 1;
        end else if (m_ie && restart_i[0] && !m_mask[0]) begin
            npc = 16'h002C; ntake = 1; acc = 1;
        end else if (m_ie && intr_i) begin
            nack = 1; acc = 1;
        end
        if (acc || di_i) m_ie = 0;
        else if (ei_i)   m_ie = 1;
        if (mask_wr_i) m_mask = mask_data_i;
        m_pc = npc; m_take = ntake; m_ack = nack;
    endtask

    task automatic cmp(string what, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_vec++;
        cmp("pc_o", pc_o, m_pc);
        cmp("take_o", take_o, m_take);
        cmp("inta_o", inta_o, m_ack);
        cmp("ie_o", ie_o, m_ie);
        cmp("mask_o", mask_o, m_mask);
        trap_i = 0; restart_i = 0; intr_i = 0; ei_i = 0; di_i = 0; mask_wr_i = 0;
    endtask

    task automatic set_mask(logic [2:0] m);
        mask_wr_i = 1; mask_data_i = m; step();
    endtask

    task automatic enable();
        ei_i = 1; step();
    endtask

    initial begin
        cur_req = "R1";
        step(); step();
        rst = 0;
        step();
        cur_req = "R2";                     // trap with ie=0, masks all set
        trap_i = 1; step(); step();
        set_mask(3'b111); enable();
        trap_i = 1; step();
        cur_req = "R3";
        set_mask(3'b000);
        for (int k = 0; k < 3; k++) begin
            enable(); restart_i = 3'(1 << k); step(); step();
        end
        cur_req = "R4";
        for (int k = 0; k < 3; k++) begin
            set_mask(3'(1 << k)); enable();
            restart_i = 3'(1 << k); step();          // masked: no take
            restart_i = 3'b111; step();              // others win
        end
        set_mask(3'b000);
        restart_i = 3'b111; step();                  // ie=0: nothing
        cur_req = "R5";
        for (int k = 0; k < 5; k++) begin
            enable();
            trap_i = (k < 1); intr_i = 1;
            restart_i = 3'b111 >> (k > 0 ? k - 1 : 0);
            if (k == 4) restart_i = 0;
            step(); data_i = 8'hE7; step(); step();
        end
        cur_req = "R6";
        intr_i = 1; step();                          // ie=0: ignored
        enable(); intr_i = 1; step();
        cur_req = "R7";
        data_i = 8'hE7; step(); step();
        enable(); intr_i = 1; step(); data_i = 8'hFF; step(); step();
        enable(); intr_i = 1; step(); data_i = 8'hC7; step(); step();
        cur_req = "R8";
        enable(); intr_i = 1; step(); data_i = 8'h3E; step(); step();
        enable(); intr_i = 1; step(); data_i = 8'hE6; step(); step();
        cur_req = "R9";
        enable(); di_i = 1; step();
        enable(); ei_i = 1; trap_i = 1; step();      // accept beats EI
        ei_i = 1; di_i = 1; step();
        cur_req = "R10";
        enable(); intr_i = 1; step();
        trap_i = 1; data_i = 8'h00; step();          // trap during ack waits
        trap_i = 1; step(); step();
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            trap_i = ($urandom % 8) == 0;
            restart_i = 3'($urandom);
            intr_i = $urandom % 2;
            ei_i = ($urandom % 3) == 0;
            di_i = ($urandom % 7) == 0;
            mask_wr_i = ($urandom % 5) == 0;
            mask_data_i = 3'($urandom);
            data_i = 8'($urandom);
            step();
        end
        cur_req = "R1";
        rst = 1; step(); rst = 0; step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule